// File: doc/BRIEF.md
# Run-Length Terminal Count Detector

This block flags the terminal count of a long maximal-length XOR shift-register counter. The counter's state is never decoded directly. The block watches only the bit being shifted into the counter, which is the counter's most significant bit. A small counter records how many ones in a row have entered the register. When that count already equals n-1 and the current incoming bit is also one, the register holds all ones, and the terminal-count pulse is raised.

The comparison works on about log2(n) bits, not n. The logic that limits the clock rate therefore stays shallow even for very wide counters. The bare shift and XOR path of the counter is not the limit, but a wide all-ones decode would be.

The detector shares the counter's clock and active-low reset. It assumes the counter resets to all ones and shifts toward its least significant bit. A parameter can add a register stage on the pulse to shorten the path that leaves the block.

Top module: `runlen_tco`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, run_cnt_o is 0 and tco_o is 0.
- R2: When shift_in_i is 0 at a rising clock edge, run_cnt_o is 0 after that edge.
- R3: When shift_in_i is 1 and run_cnt_o is below LFSR_LEN-1 at a rising edge, run_cnt_o rises by exactly one after that edge.
- R4: With PIPE_TCO = 0, tco_o is 1 in exactly those cycles where shift_in_i is 1 and run_cnt_o equals LFSR_LEN-1. Driven by the reference counter, this is exactly the cycles where the counter state is all ones, excluding the reset state.
- R5: run_cnt_o never exceeds LFSR_LEN-1. In the cycle after a terminal-count match, run_cnt_o is 0.
- R6: tco_o is never high in two consecutive cycles. The all-ones state present when reset is released is not flagged. The first pulse comes 2^LFSR_LEN-1 cycles after release, and the pulses then repeat with that period.
- R7: With PIPE_TCO = 1, tco_o is the PIPE_TCO = 0 pulse delayed by exactly one clock. run_cnt_o is unchanged by the setting.
- R8: For LFSR_LEN = 4, fed by the reference counter starting from 1111 with the new bit taken as bit1 XOR bit0, run_cnt_o reads 0,1,0,0,0,1,0,0,1,2,0,1,0,1,2,3 over the first sixteen cycles after release, and 0 in the seventeenth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the counter |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_in_i | input | 1 | Bit entering the counter (its most significant bit) |
| run_cnt_o | output | $clog2(LFSR_LEN) | Number of consecutive ones that have entered the counter |
| tco_o | output | 1 | One-cycle terminal-count pulse |

## Verification
run_cnt_o is due one clock after the incoming bit that moves it. With PIPE_TCO = 0, tco_o is due in the same cycle as the all-ones state. With PIPE_TCO = 1, it is due one cycle later.

The bench advances its reference counters just after each rising edge and pushes one expectation per cycle. The monitor pops that expectation and compares it at the following falling edge, so each pop lines up with the cycle whose state produced it. For the pipelined instance, the expected pulse is the previous cycle's unpipelined expectation. The count is modelled from the reference state (leading ones below the top bit, limited by the number of shifts since reset), never from the detector's own history.

// File: rtl/runlen_tco_pkg.sv
package runlen_tco_pkg;

  function automatic int unsigned run_cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction

endpackage

// File: rtl/runlen_counter.sv
module runlen_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!bit_i || clear_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/runlen_match.sv
module runlen_match #(
  parameter int unsigned LFSR_LEN = 4,
  parameter int unsigned CNT_W    = 2
) (
  input  logic             bit_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(LFSR_LEN - 1);

  // n-1 ones already in, one more arriving: state is all ones
  assign hit_o = bit_i && (cnt_i == RUN_LAST);

endmodule

// File: rtl/tco_stage.sv
module tco_stage #(
  parameter bit PIPE_TCO = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic tco_o
);

  if (PIPE_TCO) begin : g_reg
    logic tco_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tco_q <= 1'b0;
      else         tco_q <= hit_i;
    end
    assign tco_o = tco_q;
  end else begin : g_comb
    assign tco_o = hit_i;
  end

endmodule

// File: rtl/runlen_tco.sv
module runlen_tco #(
  parameter int unsigned LFSR_LEN = 16,
  parameter bit          PIPE_TCO = 1'b0,
  localparam int unsigned CNT_W   = runlen_tco_pkg::run_cnt_width(LFSR_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_in_i,
  output logic [CNT_W-1:0] run_cnt_o,
  output logic             tco_o
);

  logic [CNT_W-1:0] cnt;
  logic             hit;

  runlen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (shift_in_i),
    .clear_i (hit),
    .cnt_o   (cnt)
  );

  runlen_match #(.LFSR_LEN(LFSR_LEN), .CNT_W(CNT_W)) u_match (
    .bit_i (shift_in_i),
    .cnt_i (cnt),
    .hit_o (hit)
  );

  tco_stage #(.PIPE_TCO(PIPE_TCO)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .tco_o  (tco_o)
  );

  assign run_cnt_o = cnt;

endmodule

// File: rtl/runlen_tco_chk.sv
module runlen_tco_chk #(
  parameter int unsigned LFSR_LEN = 16,
  parameter bit          PIPE_TCO = 1'b0,
  parameter int unsigned CNT_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_in_i,
  input logic [CNT_W-1:0] run_cnt_o,
  input logic             tco_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LFSR_LEN - 1);

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt_o <= LAST);

  assert_zero_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_in_i |=> run_cnt_o == '0);

  assert_one_counts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_in_i && run_cnt_o < LAST) |=> run_cnt_o == $past(run_cnt_o) + CNT_W'(1));

  assert_match_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_in_i && run_cnt_o == LAST) |=> run_cnt_o == '0);

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tco_o |=> !tco_o);

  if (PIPE_TCO) begin : g_pipe
    assert_tco_delayed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_in_i && run_cnt_o == LAST) |=> tco_o);
    assert_tco_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(shift_in_i && run_cnt_o == LAST) |=> !tco_o);
  end else begin : g_comb
    assert_tco_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tco_o |-> (shift_in_i && run_cnt_o == LAST));
  end

endmodule

bind runlen_tco runlen_tco_chk #(
  .LFSR_LEN(LFSR_LEN), .PIPE_TCO(PIPE_TCO), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shift_in_i (shift_in_i),
  .run_cnt_o  (run_cnt_o),
  .tco_o      (tco_o)
);

// File: tb/sim_runlen_tco.sv
`timescale 1ns/1ps
module sim_runlen_tco;

  localparam int PER16 = 65535;
  localparam int PER4  = 15;
  localparam int STEPS = 2 * PER16 + 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [15:0] q16;
  logic [3:0]  q4;
  logic [3:0]  cnt16;
  logic [1:0]  cnt4, cnt4p;
  logic        tco16, tco4, tco4p;

  runlen_tco #(.LFSR_LEN(16), .PIPE_TCO(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .shift_in_i(q16[15]), .run_cnt_o(cnt16), .tco_o(tco16));
  runlen_tco #(.LFSR_LEN(4), .PIPE_TCO(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .shift_in_i(q4[3]), .run_cnt_o(cnt4), .tco_o(tco4));
  runlen_tco #(.LFSR_LEN(4), .PIPE_TCO(1'b1)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .shift_in_i(q4[3]), .run_cnt_o(cnt4p), .tco_o(tco4p));

  typedef struct packed { logic tco; logic [7:0] cnt; } exp_t;
  exp_t sb16[$], sb4[$], sb4p[$];

  int n_chk = 0, n_fail = 0;
  int since;
  logic prev16, prev4, dly4;
  bit done = 1'b0;

  int seq4 [16] = '{0,1,0,0,0,1,0,0,1,2,0,1,0,1,2,3};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lead_ones(input logic [15:0] v, input int w, input int lim);
    int c = 0;
    for (int i = w - 2; i >= 0; i--) begin
      if (!v[i]) break;
      c++;
    end
    return (c < lim) ? c : lim;
  endfunction

  // driver: expectation for the current reference state
  task automatic push_exp();
    exp_t e16, e4, e4p;
    e16.tco = (q16 == 16'hFFFF) && (since > 0);
    e16.cnt = prev16 ? 8'd0 : 8'(lead_ones(q16, 16, since));
    e4.tco  = (q4 == 4'hF) && (since > 0);
    e4.cnt  = prev4 ? 8'd0 : 8'(lead_ones({12'd0, q4}, 4, since));
    e4p.tco = dly4;
    e4p.cnt = e4.cnt;
    prev16 = e16.tco;
    prev4  = e4.tco;
    dly4   = e4.tco;
    sb16.push_back(e16);
    sb4.push_back(e4);
    sb4p.push_back(e4p);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    q16 = {q16[0] ^ q16[11] ^ q16[13] ^ q16[14], q16[15:1]};
    q4  = {q4[1] ^ q4[0], q4[3:1]};
    since++;
    push_exp();
  endtask

  // monitor
  int mcyc = 0;
  int p16 = 0, p4 = 0, last16 = 0, last4 = 0;
  always @(negedge clk) begin
    if (rst_n && sb16.size() > 0) begin
      exp_t a, b, c;
      a = sb16.pop_front();
      b = sb4.pop_front();
      c = sb4p.pop_front();
      chk(tco16 == a.tco, "R4 n16 tco", int'(tco16), int'(a.tco));
      chk(cnt16 == a.cnt[3:0], "R2/R3 n16 count", int'(cnt16), int'(a.cnt));
      chk(tco4 == b.tco, "R4 n4 tco", int'(tco4), int'(b.tco));
      chk(cnt4 == b.cnt[1:0], "R2/R3 n4 count", int'(cnt4), int'(b.cnt));
      chk(tco4p == c.tco, "R7 piped tco", int'(tco4p), int'(c.tco));
      chk(cnt4p == c.cnt[1:0], "R7 piped count", int'(cnt4p), int'(c.cnt));
      chk(cnt16 <= 4'd15, "R5 n16 bound", int'(cnt16), 15);
      if (mcyc == 0) begin
        chk(tco16 == 1'b0 && tco4 == 1'b0, "R1 first cycle tco", int'(tco16 | tco4), 0);
        chk(cnt16 == 0 && cnt4 == 0, "R1 first cycle count", int'(cnt16) + int'(cnt4), 0);
      end
      if (mcyc < 16) chk(int'(cnt4) == seq4[mcyc], "R8 sequence", int'(cnt4), seq4[mcyc]);
      if (mcyc == 16) chk(cnt4 == 2'd0, "R8 after match R5", int'(cnt4), 0);
      if (tco16) begin
        chk(mcyc - last16 == PER16, "R6 n16 spacing", mcyc - last16, PER16);
        last16 = mcyc;
        p16++;
      end
      if (tco4) begin
        chk(mcyc - last4 == PER4, "R6 n4 spacing", mcyc - last4, PER4);
        last4 = mcyc;
        p4++;
      end
      mcyc++;
    end
  end

  initial begin
    rst_n  = 1'b0;
    q16    = '1;
    q4     = '1;
    prev16 = 1'b0;
    prev4  = 1'b0;
    dly4   = 1'b0;
    since  = 0;
    repeat (3) @(negedge clk);
    chk(cnt16 == 0 && cnt4 == 0 && cnt4p == 0, "R1 reset count",
        int'(cnt16) + int'(cnt4) + int'(cnt4p), 0);
    chk(!tco16 && !tco4 && !tco4p, "R1 reset tco", int'(tco16 | tco4 | tco4p), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    push_exp();
    for (int i = 0; i < STEPS; i++) step();
    @(negedge clk);
    #1;
    chk(p16 == 2, "R6 n16 pulse count", p16, 2);
    chk(p4 == (STEPS / PER4), "R6 n4 pulse count", p4, STEPS / PER4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (STEPS + 2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", mcyc, STEPS + 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule